// File: doc/BRIEF.md
# Per-CPU Interrupt Interface

This block sits between a distributor and one processor. For each of a fixed set of interrupt sources it receives a request line, a trigger type (level or rising edge), a per-source enable and an 8-bit priority. Pending state is held in the block. The IRQ line to the processor is raised while at least one pending source qualifies. A source qualifies when it is enabled, not already active, and has a priority value numerically below the programmed threshold, and the block's signalling enable must also be set. The interrupt ID of a source is its index.

Software uses the block over a 32-bit register bus with four word registers, decoded from address bits 3:2. Offset 0x0 is the control register, with the signalling enable in bit 0. Offset 0x4 is the priority threshold, in bits 7:0. Offset 0x8 is the acknowledge register and is read-only. Offset 0xC is the completion register and is write-only. A read of the acknowledge register returns the ID of the best qualifying source, or 1023 when none qualifies. A successful read also marks that source active. A write of an active ID to the completion register ends handling of that source.

A read is accepted on a rising clock edge with `bus_rd` high, and its data appears on `bus_rdata` after that same edge. State updates and IRQ changes take effect after the edge on which their cause is registered.

Top module: `cpuif_top`

## Requirements
- R1: After reset `irq` is low, control and threshold read back as 0, no source is pending or active, and an acknowledge read returns 1023.
- R2: An acknowledge read returns, in bits 9:0 with bits 31:10 zero, the ID of the qualifying source with the lowest priority value. On equal priority, the lowest ID wins.
- R3: An acknowledge read when no source qualifies, including when signalling is disabled, returns 1023 and changes no state.
- R4: The threshold register holds 8 bits (bits 7:0) and reads back. Only sources whose priority value is strictly below it qualify.
- R5: Control bit 0 enables signalling and reads back. While it is 0, `irq` stays low.
- R6: A successful acknowledge makes the source active. An active source is not signalled or returned again until it is completed, even while its level request stays high.
- R7: An edge-type source (`src_edge`=1) becomes pending on a rising edge of its request. A successful acknowledge clears that pending state, so after completion it is presented again only after a new rising edge.
- R8: A completion write of an active ID (bits 9:0) clears its active state. A completion write of an ID that is not active, or is out of range, has no effect.
- R9: `irq` is high exactly when signalling is enabled and some source is pending, enabled, not active and below the threshold. It follows changes one clock edge after they are registered.
- R10: A source with `src_en` low is never signalled or acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | NUM_SRC | Request line per source |
| src_edge | input | NUM_SRC | Trigger type per source: 1 rising edge, 0 level |
| src_en | input | NUM_SRC | Per-source enable from the distributor |
| src_prio | input | 8*NUM_SRC | Priority per source, source i in bits 8i+7:8i, lower value wins |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Byte address; bits 3:2 select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq | output | 1 | Interrupt request to the processor |

## Verification
A wrong pending or active bit shows at the ports on the next edge. It appears as `irq` staying high after an acknowledge, or as a repeated or missing ID on the next acknowledge read. A completion that clears the wrong source appears when the bench reads acknowledge again while the request is still held, because the wrong ID returns or 1023 fails to appear. Arbitration or threshold faults appear on the first read: an ID that differs from the expected lowest-priority, lowest-index source, or a non-spurious value where 1023 was due.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;

    localparam int ID_W = 10;
    localparam int PRIO_W = 8;
    localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_MASK = 2'd1,
        REG_ACK  = 2'd2,
        REG_EOI  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              valid;
        logic [ID_W-1:0]   id;
        logic [PRIO_W-1:0] prio;
    } cand_t;

    function automatic logic [31:0] id_word(input logic [ID_W-1:0] id);
        return {{(32-ID_W){1'b0}}, id};
    endfunction

endpackage

// File: rtl/cpuif_src_bank.sv
module cpuif_src_bank
    import cpuif_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic [NUM_SRC-1:0] src_edge,
    input  logic               ack_fire,
    input  logic [ID_W-1:0]    ack_id,
    input  logic               eoi_fire,
    input  logic [ID_W-1:0]    eoi_id,
    output logic [NUM_SRC-1:0] pend,
    output logic [NUM_SRC-1:0] active
);
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [NUM_SRC-1:0] req_d;
    logic               eoi_hit;

    always_comb begin
        eoi_hit = 1'b0;
        if (eoi_fire && eoi_id < ID_W'(NUM_SRC))
            eoi_hit = active[eoi_id[IDX_W-1:0]];
    end

    always_ff @(posedge clk) begin
        if (rst) req_d <= '0;
        else     req_d <= src_req;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic ack_me;
        logic eoi_me;
        assign ack_me = ack_fire && (ack_id == ID_W'(i));
        assign eoi_me = eoi_hit && (eoi_id == ID_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                pend[i]   <= 1'b0;
                active[i] <= 1'b0;
            end else begin
                if (src_edge[i]) begin
                    if (src_req[i] && !req_d[i]) pend[i] <= 1'b1;
                    else if (ack_me)             pend[i] <= 1'b0;
                end else begin
                    pend[i] <= src_req[i];
                end
                if (ack_me)      active[i] <= 1'b1;
                else if (eoi_me) active[i] <= 1'b0;
            end
        end

        AST_ACK_SETS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
            ack_me |=> active[i]); // R6
    end

    AST_BAD_EOI_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (eoi_fire && !eoi_hit && !ack_fire) |=> $stable(active)); // R8

endmodule

// File: rtl/cpuif_arbiter.sv
module cpuif_arbiter
    import cpuif_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic [NUM_SRC-1:0]        pend,
    input  logic [NUM_SRC-1:0]        active,
    input  logic [NUM_SRC-1:0]        src_en,
    input  logic [PRIO_W*NUM_SRC-1:0] src_prio,
    input  logic [PRIO_W-1:0]         mask,
    input  logic                      sig_en,
    output cand_t                     best
);
    logic [NUM_SRC-1:0] elig;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
        assign elig[i] = sig_en && pend[i] && src_en[i] && !active[i]
                         && (src_prio[i*PRIO_W +: PRIO_W] < mask);
    end

    always_comb begin
        best = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (elig[i] && (!best.valid || src_prio[i*PRIO_W +: PRIO_W] < best.prio)) begin
                best.valid = 1'b1;
                best.id    = ID_W'(i);
                best.prio  = src_prio[i*PRIO_W +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/cpuif_regs.sv
module cpuif_regs
    import cpuif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [3:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    input  cand_t             best,
    output logic [31:0]       bus_rdata,
    output logic              sig_en,
    output logic [PRIO_W-1:0] mask,
    output logic              ack_fire,
    output logic [ID_W-1:0]   ack_id,
    output logic              eoi_fire,
    output logic [ID_W-1:0]   eoi_id
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(bus_addr[3:2]);

    assign ack_fire = bus_rd && (sel == REG_ACK) && best.valid;
    assign ack_id   = best.id;
    assign eoi_fire = bus_wr && (sel == REG_EOI);
    assign eoi_id   = bus_wdata[ID_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            sig_en    <= 1'b0;
            mask      <= '0;
            bus_rdata <= '0;
        end else begin
            if (bus_wr && sel == REG_CTRL) sig_en <= bus_wdata[0];
            if (bus_wr && sel == REG_MASK) mask   <= bus_wdata[PRIO_W-1:0];
            if (bus_rd) begin
                case (sel)
                    REG_CTRL: bus_rdata <= {31'd0, sig_en};
                    REG_MASK: bus_rdata <= {{(32-PRIO_W){1'b0}}, mask};
                    REG_ACK:  bus_rdata <= best.valid ? id_word(best.id) : id_word(SPURIOUS_ID);
                    default:  bus_rdata <= '0;
                endcase
            end
        end
    end

    AST_SPURIOUS_READ: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && sel == REG_ACK && !best.valid) |=> (bus_rdata == 32'd1023)); // R3

endmodule

// File: rtl/cpuif_top.sv
module cpuif_top
    import cpuif_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_SRC-1:0]        src_req,
    input  logic [NUM_SRC-1:0]        src_edge,
    input  logic [NUM_SRC-1:0]        src_en,
    input  logic [PRIO_W*NUM_SRC-1:0] src_prio,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [3:0]                bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    output logic                      irq
);
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] active;
    logic               sig_en;
    logic [PRIO_W-1:0]  mask;
    logic               ack_fire;
    logic [ID_W-1:0]    ack_id;
    logic               eoi_fire;
    logic [ID_W-1:0]    eoi_id;
    cand_t              best;

    cpuif_src_bank #(.NUM_SRC(NUM_SRC)) u_bank (
        .clk(clk), .rst(rst), .src_req(src_req), .src_edge(src_edge),
        .ack_fire(ack_fire), .ack_id(ack_id), .eoi_fire(eoi_fire), .eoi_id(eoi_id),
        .pend(pend), .active(active)
    );

    cpuif_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
        .pend(pend), .active(active), .src_en(src_en), .src_prio(src_prio),
        .mask(mask), .sig_en(sig_en), .best(best)
    );

    cpuif_regs u_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .best(best), .bus_rdata(bus_rdata), .sig_en(sig_en),
        .mask(mask), .ack_fire(ack_fire), .ack_id(ack_id), .eoi_fire(eoi_fire),
        .eoi_id(eoi_id)
    );

    assign irq = best.valid;

    AST_IRQ_GATED_BY_ENABLE: assert property (@(posedge clk) disable iff (rst)
        !sig_en |-> !irq); // R5

    AST_IRQ_BELOW_MASK: assert property (@(posedge clk) disable iff (rst)
        irq |-> (best.prio < mask)); // R4

    AST_ACK_ID_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        ack_fire |=> (bus_rdata[31:ID_W] == '0 && bus_rdata[ID_W-1:0] < ID_W'(NUM_SRC))); // R2

    AST_ACK_BLOCKS_IRQ_SRC: assert property (@(posedge clk) disable iff (rst)
        ack_fire |=> !(best.valid && best.id == $past(ack_id))); // R6

endmodule

// File: tb/sim_cpuif_top.sv
module sim_cpuif_top;
    localparam int N = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [N-1:0]   src_req = '0;
    logic [N-1:0]   src_edge = '0;
    logic [N-1:0]   src_en = '0;
    logic [8*N-1:0] src_prio = '0;
    logic           bus_wr = 1'b0;
    logic           bus_rd = 1'b0;
    logic [3:0]     bus_addr = '0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic           irq;

    cpuif_top #(.NUM_SRC(N)) u0 (
        .clk(clk), .rst(rst), .src_req(src_req), .src_edge(src_edge), .src_en(src_en),
        .src_prio(src_prio), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #2.5 clk = ~clk;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    exp_q[$];
    string tag_q[$];
    logic  rd_d = 1'b0;
    bit    done = 1'b0;

    localparam logic [3:0] A_CTRL = 4'h0, A_MASK = 4'h4, A_ACK = 4'h8, A_EOI = 4'hC;

    always @(posedge clk) rd_d <= bus_rd;

    // monitor: pops expected read data after each read cycle
    always @(negedge clk) begin
        if (rd_d && exp_q.size() > 0) begin
            int    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_tests++;
            if (bus_rdata !== 32'(e)) begin
                n_fail++;
                $display("FAIL %s: rdata=%0d expected=%0d", t, bus_rdata, e);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input int e, input string t);
        @(negedge clk);
        exp_q.push_back(e); tag_q.push_back(t);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        @(negedge clk);
        n_tests++;
        if (irq !== e) begin
            n_fail++;
            $display("FAIL %s: irq=%0b expected=%0b", t, irq, e);
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic set_src(input int i, input logic edg, input logic en, input logic [7:0] p);
        src_edge[i] = edg; src_en[i] = en; src_prio[i*8 +: 8] = p;
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        // R1 reset state
        chk_irq(1'b0, "R1 irq after reset");
        rd(A_CTRL, 0, "R1 ctrl reset");
        rd(A_MASK, 0, "R1 mask reset");
        rd(A_ACK, 1023, "R1 ack after reset");

        // R5 / R4 register readback
        wr(A_MASK, 32'h0000_01F0);
        rd(A_MASK, 'hF0, "R4 mask readback 8 bits");
        set_src(3, 1'b0, 1'b1, 8'hA0);
        src_req[3] = 1'b1;
        idle(2);
        chk_irq(1'b0, "R5 irq low while disabled");
        rd(A_ACK, 1023, "R3 ack while disabled");
        wr(A_CTRL, 32'h1);
        rd(A_CTRL, 1, "R5 ctrl readback");
        chk_irq(1'b1, "R9 irq with qualifying level source");
        rd(A_ACK, 3, "R2 ack returns id 3");
        chk_irq(1'b0, "R6 irq drops after ack");
        rd(A_ACK, 1023, "R6 active not re-presented");
        wr(A_EOI, 32'd5);
        rd(A_ACK, 1023, "R8 eoi of non-active id ignored");
        wr(A_EOI, 32'd1023);
        chk_irq(1'b0, "R8 out-of-range eoi ignored");
        wr(A_EOI, 32'd3);
        chk_irq(1'b1, "R8 eoi clears active, level re-signals");
        rd(A_ACK, 3, "R8 id 3 presented again");
        src_req[3] = 1'b0;
        wr(A_EOI, 32'd3);
        idle(2);
        chk_irq(1'b0, "R9 irq low with nothing pending");

        // R4 threshold strictness
        set_src(4, 1'b0, 1'b1, 8'hF0);
        src_req[4] = 1'b1;
        idle(2);
        chk_irq(1'b0, "R4 prio equal to mask blocked");
        rd(A_ACK, 1023, "R4 ack blocked by mask");
        wr(A_MASK, 32'hF1);
        chk_irq(1'b1, "R4 prio below raised mask signals");
        rd(A_ACK, 4, "R4 ack id 4");
        src_req[4] = 1'b0;
        wr(A_EOI, 32'd4);
        wr(A_MASK, 32'hF0);

        // R2 priority ordering with tie
        set_src(1, 1'b0, 1'b1, 8'h80);
        set_src(2, 1'b0, 1'b1, 8'h40);
        set_src(5, 1'b0, 1'b1, 8'h40);
        src_req[1] = 1'b1; src_req[2] = 1'b1; src_req[5] = 1'b1;
        idle(2);
        rd(A_ACK, 2, "R2 lowest prio, lowest id on tie");
        rd(A_ACK, 5, "R2 tie second");
        rd(A_ACK, 1, "R2 lower priority last");
        rd(A_ACK, 1023, "R3 all active");
        src_req[1] = 1'b0; src_req[2] = 1'b0; src_req[5] = 1'b0;
        wr(A_EOI, 32'd2);
        wr(A_EOI, 32'd5);
        wr(A_EOI, 32'd1);
        idle(2);
        chk_irq(1'b0, "R8 all completed, none pending");

        // R7 edge source
        set_src(6, 1'b1, 1'b1, 8'h10);
        @(negedge clk); src_req[6] = 1'b1;
        @(negedge clk); src_req[6] = 1'b0;
        idle(1);
        chk_irq(1'b1, "R7 edge latched pending");
        rd(A_ACK, 6, "R7 ack edge id 6");
        wr(A_EOI, 32'd6);
        chk_irq(1'b0, "R7 pending cleared by ack");
        rd(A_ACK, 1023, "R7 no re-present without new edge");
        @(negedge clk); src_req[6] = 1'b1;
        idle(2);
        rd(A_ACK, 6, "R7 new edge presents again");
        wr(A_EOI, 32'd6);
        idle(2);
        chk_irq(1'b0, "R7 held high, no new edge");
        src_req[6] = 1'b0;

        // R10 disabled source
        set_src(7, 1'b0, 1'b0, 8'h00);
        src_req[7] = 1'b1;
        idle(2);
        chk_irq(1'b0, "R10 disabled source not signalled");
        rd(A_ACK, 1023, "R10 disabled source not acked");

        idle(2);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual=timeout expected=done");
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule